// File: doc/BRIEF.md
# Masked Tag Match for Locked Cache Lines

This block is the tag-comparison stage of a small instruction/data cache. It compares one fetch address against the stored tag of every line. Two designated lines differ from the rest: each has its own bit mask. When such a line is locked, a set mask bit makes the matching address bit agree with the tag bit, whatever their values. A single locked line whose tag holds an interrupt vector base can then answer the opening instructions of every vector placed at a fixed, power-of-two spacing. The two masks are independent, so the two lines can cover different families of addresses.

A lookup is sampled on a clock edge while `fetch_valid` is high. One cycle later a registered result appears. A small state machine classifies the result, and the outputs are decoded from its state. The states are ST_IDLE (no lookup was sampled), ST_HIT (exactly one line matched, served with zero wait states), ST_MISS (no line matched) and ST_CONFLICT (more than one line matched, which has no defined outcome). Every edge re-evaluates the state from the current inputs:
- `fetch_valid` low goes to ST_IDLE.
- Otherwise, a multi-match goes to ST_CONFLICT.
- Otherwise, any match goes to ST_HIT.
- Otherwise, the state goes to ST_MISS.

When a masked line hits and prefetch is enabled, the block also asks for the next 16-byte line after the fetch address.

Top module: `mtm_tag_match`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hit_vec`, `zw_hit`, `miss`, `multi_err`, `pf_req` and `pf_addr` are all zero.
- R2: A line that is neither line 10 nor line 11 matches only when fetch address bits 31..4 equal its 28-bit tag exactly.
- R3: Line 10 uses `mask_a` and line 11 uses `mask_b`. Mask bit k covers address bit k+5, so the mask spans bits 5..14. While the line's lock bit is 1, a set mask bit makes that address bit match regardless of the tag. Address bit 4 and bits 15..31 always compare exactly. While the lock bit is 0, the line compares exactly.
- R4: The two masks act independently, so lines 10 and 11 can match different spacings at the same time.
- R5: A line whose valid bit is 0 never matches.
- R6: Results appear in the cycle after the edge that sampled `fetch_valid`. An edge with `fetch_valid` low gives all-zero outputs in the next cycle.
- R7: When exactly one line matches, `hit_vec` is one-hot with the bit of that line (bit i = line i), and `zw_hit` is 1.
- R8: When two or more lines match, `multi_err` is 1, and `hit_vec`, `zw_hit` and `pf_req` are 0.
- R9: `pf_req` is 1 only for a single hit on line 10 or 11 while `pf_enable` was 1. In that case `pf_addr` = {fetch address bits 31..4 plus one, 4'b0}. Otherwise `pf_req` and `pf_addr` are 0.
- R10: When no line matches, `miss` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A lookup is presented this cycle |
| fetch_addr | input | 32 | Byte address of the fetch |
| pf_enable | input | 1 | Allow next-line requests after masked hits |
| line_tags | input | 448 | Tags, line i in bits [28*i+27 : 28*i] |
| line_valid | input | 16 | Per-line valid bits |
| line_lock | input | 16 | Per-line lock bits (only lines 10, 11 use them) |
| mask_a | input | 10 | Mask for line 10, bit k covers address bit k+5 |
| mask_b | input | 10 | Mask for line 11, bit k covers address bit k+5 |
| hit_vec | output | 16 | One-hot matching line on a single hit |
| zw_hit | output | 1 | Single hit, served without wait states |
| miss | output | 1 | No line matched |
| multi_err | output | 1 | More than one line matched |
| pf_req | output | 1 | Request prefetch of the next line |
| pf_addr | output | 32 | Address of the requested next line |

## Verification
The bench sets a 32-byte spacing on line 10 and a 1 KB spacing on line 11 at the same time. It then probes addresses that differ only in bit 4, in a bit just outside the mask, and in bit 15.
- A mask window shifted by one bit would let one of those probes hit.
- A lookup that ignores the lock bit would hit after the lock is cleared.
- If the masks were swapped between the lines, one of the two spacings would fail.

The bench also forces an exact line and a masked line onto the same address. A design that picked one of them would show a hit vector or a prefetch request instead of the error. It further checks the prefetch address, including the increment into bit 4, and checks that the request stays quiet with prefetch disabled or on an ordinary line.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HIT      = 2'd1,
        ST_MISS     = 2'd2,
        ST_CONFLICT = 2'd3
    } mtm_state_e;
endpackage

// File: rtl/mtm_line_cmp.sv
module mtm_line_cmp #(
    parameter int  TAG_W      = 28,
    parameter int  MASK_W     = 10,
    parameter int  MASK_SHIFT = 1,
    parameter bit  MASKABLE   = 1'b0
) (
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic              valid,
    input  logic              lock,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [TAG_W-1:0] mask_ext;
    logic [TAG_W-1:0] mask_eff;
    logic [TAG_W-1:0] diff;

    // Place the mask over the tag bits that it covers.
    assign mask_ext = {{(TAG_W-MASK_W){1'b0}}, mask} << MASK_SHIFT;
    // The mask takes effect only on a maskable line that is locked.
    assign mask_eff = mask_ext & {TAG_W{lock & MASKABLE}};
    assign diff     = (addr_tag ^ line_tag) & ~mask_eff;
    assign hit      = valid && (diff == '0);
endmodule

// File: rtl/mtm_hit_resolve.sv
module mtm_hit_resolve #(
    parameter int NUM_LINES  = 16,
    parameter int MASK_LINE0 = 10,
    parameter int MASK_LINE1 = 11
) (
    input  logic [NUM_LINES-1:0] hits,
    output logic                 any_hit,
    output logic                 multi_hit,
    output logic                 masked_hit
);
    logic seen;

    always_comb begin
        seen      = 1'b0;
        multi_hit = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (hits[i]) begin
                if (seen) multi_hit = 1'b1;
                seen = 1'b1;
            end
        end
        any_hit    = seen;
        masked_hit = hits[MASK_LINE0] | hits[MASK_LINE1];
    end
endmodule

// File: rtl/mtm_tag_match.sv
module mtm_tag_match
    import mtm_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 4,
    parameter int MASK_LO    = 5,
    parameter int MASK_W     = 10,
    parameter int MASK_LINE0 = 10,
    parameter int MASK_LINE1 = 11,
    localparam int TAG_W      = ADDR_W - OFF_W,
    localparam int MASK_SHIFT = MASK_LO - OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [ADDR_W-1:0]          fetch_addr,
    input  logic                       pf_enable,
    input  logic [NUM_LINES*TAG_W-1:0] line_tags,
    input  logic [NUM_LINES-1:0]       line_valid,
    input  logic [NUM_LINES-1:0]       line_lock,
    input  logic [MASK_W-1:0]          mask_a,
    input  logic [MASK_W-1:0]          mask_b,
    output logic [NUM_LINES-1:0]       hit_vec,
    output logic                       zw_hit,
    output logic                       miss,
    output logic                       multi_err,
    output logic                       pf_req,
    output logic [ADDR_W-1:0]          pf_addr
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [TAG_W-1:0]     addr_tag;
    logic [NUM_LINES-1:0] hits;
    logic                 any_hit, multi_hit, masked_hit;

    mtm_state_e           state_q, state_d;
    logic [NUM_LINES-1:0] hit_vec_q;
    logic                 pf_q;
    logic [ADDR_W-1:0]    pf_addr_q;

    assign addr_tag = fetch_addr[ADDR_W-1:OFF_W];

    // One comparator per line; the designated lines get their own mask.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i == MASK_LINE0) begin : g_mask0
            mtm_line_cmp #(.TAG_W(TAG_W), .MASK_W(MASK_W),
                           .MASK_SHIFT(MASK_SHIFT), .MASKABLE(1'b1)) u_cmp (
                .addr_tag (addr_tag),
                .line_tag (line_tags[i*TAG_W +: TAG_W]),
                .valid    (line_valid[i]),
                .lock     (line_lock[i]),
                .mask     (mask_a),
                .hit      (hits[i])
            );
        end else if (i == MASK_LINE1) begin : g_mask1
            mtm_line_cmp #(.TAG_W(TAG_W), .MASK_W(MASK_W),
                           .MASK_SHIFT(MASK_SHIFT), .MASKABLE(1'b1)) u_cmp (
                .addr_tag (addr_tag),
                .line_tag (line_tags[i*TAG_W +: TAG_W]),
                .valid    (line_valid[i]),
                .lock     (line_lock[i]),
                .mask     (mask_b),
                .hit      (hits[i])
            );
        end else begin : g_exact
            mtm_line_cmp #(.TAG_W(TAG_W), .MASK_W(MASK_W),
                           .MASK_SHIFT(MASK_SHIFT), .MASKABLE(1'b0)) u_cmp (
                .addr_tag (addr_tag),
                .line_tag (line_tags[i*TAG_W +: TAG_W]),
                .valid    (line_valid[i]),
                .lock     (line_lock[i]),
                .mask     ('0),
                .hit      (hits[i])
            );
        end
    end

    mtm_hit_resolve #(
        .NUM_LINES (NUM_LINES),
        .MASK_LINE0(MASK_LINE0),
        .MASK_LINE1(MASK_LINE1)
    ) u_resolve (
        .hits      (hits),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .masked_hit(masked_hit)
    );

    // Next-state decision.
    always_comb begin
        if (!fetch_valid)   state_d = ST_IDLE;
        else if (multi_hit) state_d = ST_CONFLICT;
        else if (any_hit)   state_d = ST_HIT;
        else                state_d = ST_MISS;
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hit_vec_q <= '0;
            pf_q      <= 1'b0;
            pf_addr_q <= '0;
        end else begin
            state_q   <= state_d;
            hit_vec_q <= (fetch_valid && !multi_hit) ? hits : '0;
            pf_q      <= fetch_valid && !multi_hit && masked_hit && pf_enable;
            pf_addr_q <= {addr_tag + TAG_W'(1), {OFF_W{1'b0}}};
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        hit_vec   = '0;
        zw_hit    = 1'b0;
        miss      = 1'b0;
        multi_err = 1'b0;
        pf_req    = 1'b0;
        pf_addr   = '0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_HIT: begin
                hit_vec = hit_vec_q;
                zw_hit  = 1'b1;
                pf_req  = pf_q;
                pf_addr = pf_q ? pf_addr_q : '0;
            end
            ST_MISS:     miss      = 1'b1;
            ST_CONFLICT: multi_err = 1'b1;
            default:     ;
        endcase
    end

    // ---------------- assertions ----------------
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

    AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |-> (hit_vec == '0 && !zw_hit && !pf_req)); // R8

    AST_IDLE_AFTER_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (hit_vec == '0 && !zw_hit && !miss && !multi_err && !pf_req)); // R6

    AST_PF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |-> $past(pf_enable)); // R9

    AST_PF_MASKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |-> (hit_vec[MASK_LINE0] | hit_vec[MASK_LINE1])); // R9

    AST_ZW_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        zw_hit |-> ($countones(hit_vec) == 1)); // R7

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_chk
        AST_BIT4_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[j] |-> ($past(fetch_addr[OFF_W]) == $past(line_tags[j*TAG_W]))); // R3
        AST_VALID_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[j] |-> $past(line_valid[j])); // R5
    end
endmodule

// File: tb/mtm_tag_match_tb.sv
module mtm_tag_match_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NL    = 16;
    localparam int TAG_W = 28;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fetch_valid;
    logic [31:0]       fetch_addr;
    logic              pf_enable;
    logic [TAG_W-1:0]  tags [NL];
    logic [NL*TAG_W-1:0] line_tags;
    logic [NL-1:0]     line_valid, line_lock;
    logic [9:0]        mask_a, mask_b;
    logic [NL-1:0]     hit_vec;
    logic              zw_hit, miss, multi_err, pf_req;
    logic [31:0]       pf_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] BASE_A = 32'h9D00_0000;
    localparam logic [31:0] BASE_B = 32'h9D01_0000;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) line_tags[i*TAG_W +: TAG_W] = tags[i];
    end

    mtm_tag_match u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .pf_enable(pf_enable), .line_tags(line_tags), .line_valid(line_valid),
        .line_lock(line_lock), .mask_a(mask_a), .mask_b(mask_b),
        .hit_vec(hit_vec), .zw_hit(zw_hit), .miss(miss), .multi_err(multi_err),
        .pf_req(pf_req), .pf_addr(pf_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one lookup and sample its result one cycle later.
    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(posedge clk);
        #1;
        fetch_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input int line, input bit pf, input logic [31:0] pa);
        chk({req, " hit_vec"}, 64'(hit_vec), 64'(16'(1) << line));
        chk({req, " zw_hit"},  64'(zw_hit), 64'd1);
        chk({req, " miss"},    64'(miss), 64'd0);
        chk({req, " pf_req"},  64'(pf_req), 64'(pf));
        chk({req, " pf_addr"}, 64'(pf_addr), 64'(pa));
    endtask

    task automatic expect_miss(input string req);
        chk({req, " miss"},    64'(miss), 64'd1);
        chk({req, " hit_vec"}, 64'(hit_vec), 64'd0);
        chk({req, " zw_hit"},  64'(zw_hit), 64'd0);
        chk({req, " pf_req"},  64'(pf_req), 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 hit_vec in reset", 64'(hit_vec), 64'd0);
        chk("R1 flags in reset", 64'({zw_hit, miss, multi_err, pf_req}), 64'd0);
        chk("R1 pf_addr in reset", 64'(pf_addr), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 flags after reset", 64'({zw_hit, miss, multi_err, pf_req}), 64'd0);
    endtask

    task automatic t_exact;
        tags[3] = 28'(32'h0000_1000 >> 4);
        line_valid[3] = 1'b1;
        pf_enable = 1'b1;
        lookup(32'h0000_1008);
        expect_hit("R2 R7 exact line", 3, 1'b0, 32'h0);   // R9: no prefetch for an exact line
        lookup(32'h0000_1010);
        expect_miss("R2 R10 neighbour line");
        lookup(32'h0000_3000);
        expect_miss("R2 R10 far address");
    endtask

    task automatic t_valid;
        line_valid[3] = 1'b0;
        lookup(32'h0000_1000);
        expect_miss("R5 invalid line");
        line_valid[3] = 1'b1;
    endtask

    task automatic t_masks;
        tags[10] = 28'(BASE_A >> 4);
        tags[11] = 28'(BASE_B >> 4);
        line_valid[10] = 1'b1; line_valid[11] = 1'b1;
        line_lock[10]  = 1'b1; line_lock[11]  = 1'b1;
        mask_a = 10'h01F;   // 32-byte spacing
        mask_b = 10'h3E0;   // 1 KB spacing
        lookup(BASE_A + 32'h64);
        expect_hit("R3 R9 line10 masked", 10, 1'b1, BASE_A + 32'h70);
        lookup(BASE_A + 32'h74);
        expect_miss("R3 bit4 exact");
        lookup(BASE_A + 32'h400);
        expect_miss("R3 bit10 outside mask_a");
        lookup(BASE_B + 32'h2400);
        expect_hit("R4 line11 masked", 11, 1'b1, BASE_B + 32'h2410);
        lookup(BASE_B + 32'h20);
        expect_miss("R4 bit5 outside mask_b");
        mask_a = 10'h3FF;
        lookup(BASE_A + 32'h7FE0);
        expect_hit("R3 full mask", 10, 1'b1, BASE_A + 32'h7FF0);
        lookup(BASE_A + 32'h8000);
        expect_miss("R3 bit15 exact");
        mask_a = 10'h01F;
    endtask

    task automatic t_lock;
        line_lock[10] = 1'b0;
        lookup(BASE_A + 32'h60);
        expect_miss("R3 unlocked no mask");
        lookup(BASE_A + 32'h4);
        expect_hit("R3 unlocked exact", 10, 1'b1, BASE_A + 32'h10);
        line_lock[10] = 1'b1;
    endtask

    task automatic t_pf_off;
        pf_enable = 1'b0;
        lookup(BASE_A + 32'h60);
        expect_hit("R9 prefetch disabled", 10, 1'b0, 32'h0);
        pf_enable = 1'b1;
    endtask

    task automatic t_multi;
        tags[3] = 28'((BASE_A + 32'h60) >> 4);
        lookup(BASE_A + 32'h60);
        chk("R8 multi_err", 64'(multi_err), 64'd1);
        chk("R8 hit_vec", 64'(hit_vec), 64'd0);
        chk("R8 zw_hit", 64'(zw_hit), 64'd0);
        chk("R8 pf_req", 64'(pf_req), 64'd0);
        chk("R8 miss", 64'(miss), 64'd0);
        tags[3] = 28'(32'h0000_1000 >> 4);
    endtask

    task automatic t_idle;
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_addr  = BASE_A + 32'h60;
        @(posedge clk); #1;
        chk("R6 idle outputs", 64'({hit_vec, zw_hit, miss, multi_err, pf_req}), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; pf_enable = 1'b0;
        line_valid = '0; line_lock = '0; mask_a = '0; mask_b = '0;
        for (int i = 0; i < NL; i++) tags[i] = '0;
        repeat (3) @(posedge clk);
        t_reset;
        t_exact;
        t_valid;
        t_masks;
        t_lock;
        t_pf_off;
        t_multi;
        t_idle;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule